// File: doc/BRIEF.md
# One-Wire Temperature Read Sequencer

This block is a bus master for a single open-drain one-wire line. It carries out one complete temperature-read transaction against a sensor. A one-cycle `start` sets it going. It first produces a bus reset and checks for a presence reply. It then sends the byte that addresses every device on the line, followed by the start-conversion byte. Next it waits out the conversion time. If `parasite_mode` was high at start, it drives the active strong pull-up for that whole time and keeps all other traffic off the bus. After the wait it resets the bus again, addresses all devices once more and sends the scratchpad-read byte. It then reads back two bytes.

All bus timing is counted in whole microseconds, from a tick that a parameterized clock divider derives from the system clock. The divider is restarted at the start of every slot and at the start of the conversion wait, so each pulse width is an exact multiple of the microsecond. When the read finishes, the 16-bit result is presented and `done` pulses for one cycle. If a presence reply is missing at either reset, `error` pulses instead and the block returns to idle.

Top module: `owt_temp_reader`

## Requirements
- R1: The reset pulse holds `bus_drive_low` high for exactly RST_LOW_US (480) µs. The line is sampled PRES_US (70) µs after release. If the line is high at that sample, `error` pulses for one cycle, no further slot is started and `done` stays low.
- R2: The bytes go out least significant bit first and in this order: reset, 0xCC, 0x44, conversion wait, reset, 0xCC, 0xBE, then the read slots.
- R3: A written 0 holds the line low for exactly SLOT_US (60) µs. A written 1, like a read slot, holds it low for exactly LOW_US (2) µs. Consecutive slot starts are at least SLOT_US+REC_US (62) µs apart.
- R4: A read slot releases the line after LOW_US and samples it SAMPLE_US (12) µs after the slot start. A device that holds the line low for 14 µs from the slot start is read as a 0.
- R5: With parasite mode latched at start, `bus_strong_pu` rises once, after the last slot of the 0x44 byte. It stays high for exactly PULLUP_US µs, and no slot or reset happens while it is high.
- R6: With parasite mode low at start, `bus_strong_pu` never rises. The same conversion wait passes with the line released.
- R7: After reset every output is low and `temp_raw` is zero. `bus_drive_low` and `bus_strong_pu` are never high in the same cycle.
- R8: `temp_raw` = {second byte read, first byte read}, each byte assembled LSB first. `done` is a single-cycle pulse, and `temp_raw` changes only in the cycle where `done` is high.
- R9: A `start` pulse during a transaction is ignored. The transaction in progress continues unchanged and completes with a single `done`.
- R10: A missing presence reply at the second reset pulses `error` after the first two bytes have gone out. `done` stays low and `temp_raw` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run a transaction |
| parasite_mode | input | 1 | Latched at start; selects the strong pull-up during conversion |
| bus_sense | input | 1 | Level of the one-wire line |
| bus_drive_low | output | 1 | Enables the open-drain pull-down of the line |
| bus_strong_pu | output | 1 | Enables the active strong pull-up of the line |
| temp_raw | output | 8*RD_BYTES | Raw temperature, high byte above low byte |
| done | output | 1 | One-cycle pulse when `temp_raw` is updated |
| error | output | 1 | One-cycle pulse when a presence reply is missing |

## Verification
The hardest case to reach is a presence reply that vanishes at the second reset. By then the sequencer has already sent two bytes and finished the whole conversion wait. The bench's device model can be told which resets it answers, so it answers the first and stays silent on the second. The narrow read window is also deliberate: the model pulls the line low for only 14 µs for each 0 bit. A master that samples late therefore reads ones, and this shows up across a sweep of temperature words that includes all-zero, all-one and mixed patterns.

// File: rtl/owt_pkg.sv
package owt_pkg;

    typedef enum logic [1:0] {
        SK_RESET,
        SK_WR0,
        SK_WR1,
        SK_READ
    } slot_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RESET,
        PH_WRITE,
        PH_CONV,
        PH_READ
    } phase_e;

    localparam logic [7:0] OP_ALL_DEV  = 8'hCC;
    localparam logic [7:0] OP_CONVERT  = 8'h44;
    localparam logic [7:0] OP_READ_PAD = 8'hBE;

    // byte 0 of each pass addresses all devices; byte 1 is the function
    function automatic logic [7:0] cmd_byte(input logic second_pass, input logic idx);
        if (!idx) begin
            return OP_ALL_DEV;
        end
        return second_pass ? OP_READ_PAD : OP_CONVERT;
    endfunction

endpackage

// File: rtl/owt_us_timer.sv
module owt_us_timer #(
    parameter int unsigned CLK_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (restart || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/owt_slot_engine.sv
module owt_slot_engine
    import owt_pkg::*;
#(
    parameter int unsigned RST_LOW_US  = 480,
    parameter int unsigned RST_HIGH_US = 480,
    parameter int unsigned PRES_US     = 70,
    parameter int unsigned SLOT_US     = 60,
    parameter int unsigned REC_US      = 2,
    parameter int unsigned LOW_US      = 2,
    parameter int unsigned SAMPLE_US   = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_valid,
    input  slot_kind_e cmd_kind,
    input  logic       line_in,
    output logic       restart,
    output logic       drive_low,
    output logic       busy,
    output logic       slot_done,
    output logic       rx_bit
);
    localparam int unsigned RST_TOT  = RST_LOW_US + RST_HIGH_US;
    localparam int unsigned SLOT_TOT = SLOT_US + REC_US;
    localparam int unsigned SPAN     = (RST_TOT > SLOT_TOT) ? RST_TOT : SLOT_TOT;
    localparam int unsigned UW       = $clog2(SPAN + 1);

    localparam logic [UW-1:0] RST_LOW_C  = UW'(RST_LOW_US);
    localparam logic [UW-1:0] RST_END_C  = UW'(RST_TOT);
    localparam logic [UW-1:0] PRES_AT_C  = UW'(RST_LOW_US + PRES_US);
    localparam logic [UW-1:0] SLOT_C     = UW'(SLOT_US);
    localparam logic [UW-1:0] SLOT_END_C = UW'(SLOT_TOT);
    localparam logic [UW-1:0] LOW_C      = UW'(LOW_US);
    localparam logic [UW-1:0] SAMPLE_C   = UW'(SAMPLE_US);

    typedef struct packed {
        logic          active;
        slot_kind_e    kind;
        logic [UW-1:0] us_cnt;
        logic          drive;
        logic          done;
        logic          rx_bit;
        logic [1:0]    sync;
    } eng_st_t;

    localparam eng_st_t ENG_RST = '{
        active: 1'b0, kind: SK_RESET, us_cnt: '0, drive: 1'b0,
        done: 1'b0, rx_bit: 1'b1, sync: 2'b11
    };

    eng_st_t st_d, st_q;
    logic [UW-1:0] low_len, end_at, smp_at;
    logic          do_smp;

    // per-kind shape of the slot
    always_comb begin
        low_len = SLOT_C;
        end_at  = SLOT_END_C;
        smp_at  = SAMPLE_C;
        do_smp  = 1'b0;
        case (st_q.kind)
            SK_RESET: begin
                low_len = RST_LOW_C;
                end_at  = RST_END_C;
                smp_at  = PRES_AT_C;
                do_smp  = 1'b1;
            end
            SK_WR0: begin
                low_len = SLOT_C;
            end
            SK_WR1: begin
                low_len = LOW_C;
            end
            SK_READ: begin
                low_len = LOW_C;
                smp_at  = SAMPLE_C;
                do_smp  = 1'b1;
            end
            default: begin
                low_len = SLOT_C;
            end
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.sync = {st_q.sync[0], line_in};
        restart   = 1'b0;
        if (!st_q.active) begin
            if (cmd_valid) begin
                st_d.active = 1'b1;
                st_d.kind   = cmd_kind;
                st_d.us_cnt = '0;
                st_d.drive  = 1'b1;
                restart     = 1'b1;
            end
        end else if (tick) begin
            st_d.us_cnt = st_q.us_cnt + 1'b1;
            st_d.drive  = (st_d.us_cnt < low_len);
            if (do_smp && st_d.us_cnt == smp_at) begin
                st_d.rx_bit = st_q.sync[1];
            end
            if (st_d.us_cnt == end_at) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
                st_d.drive  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ENG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_low = st_q.drive;
    assign busy      = st_q.active;
    assign slot_done = st_q.done;
    assign rx_bit    = st_q.rx_bit;

    AST_CMD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> !busy); // R2
    AST_SLOT_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> drive_low); // R3
    AST_SLOT_ENDS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) slot_done |-> !drive_low); // R3
    AST_SLOT_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) slot_done |=> !slot_done); // R3

endmodule

// File: rtl/owt_temp_reader.sv
module owt_temp_reader
    import owt_pkg::*;
#(
    parameter int unsigned CLK_PER_US  = 100,
    parameter int unsigned PULLUP_US   = 10000,
    parameter int unsigned RD_BYTES    = 2,
    parameter int unsigned RST_LOW_US  = 480,
    parameter int unsigned RST_HIGH_US = 480,
    parameter int unsigned PRES_US     = 70,
    parameter int unsigned SLOT_US     = 60,
    parameter int unsigned REC_US      = 2,
    parameter int unsigned LOW_US      = 2,
    parameter int unsigned SAMPLE_US   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    parasite_mode,
    input  logic                    bus_sense,
    output logic                    bus_drive_low,
    output logic                    bus_strong_pu,
    output logic [8*RD_BYTES-1:0]   temp_raw,
    output logic                    done,
    output logic                    error
);
    localparam int unsigned RD_BITS = 8 * RD_BYTES;
    localparam int unsigned RCW     = $clog2(RD_BITS);
    localparam int unsigned CVW     = $clog2(PULLUP_US + 1);
    localparam logic [RCW-1:0] RD_LAST = RCW'(RD_BITS - 1);
    localparam logic [CVW-1:0] CV_END  = CVW'(PULLUP_US);

    typedef struct packed {
        phase_e             phase;
        logic               pass;
        logic               byte_idx;
        logic [2:0]         bit_idx;
        logic [RCW-1:0]     rd_cnt;
        logic [RD_BITS-1:0] shreg;
        logic               parasite;
        logic [CVW-1:0]     conv_cnt;
        logic               pu;
        logic               cmd_valid;
        slot_kind_e         cmd_kind;
        logic [RD_BITS-1:0] result;
        logic               done;
        logic               err;
    } seq_st_t;

    localparam seq_st_t SEQ_RST = '{
        phase: PH_IDLE, pass: 1'b0, byte_idx: 1'b0, bit_idx: '0, rd_cnt: '0,
        shreg: '0, parasite: 1'b0, conv_cnt: '0, pu: 1'b0, cmd_valid: 1'b0,
        cmd_kind: SK_RESET, result: '0, done: 1'b0, err: 1'b0
    };

    seq_st_t st_d, st_q;

    logic tick, eng_restart, conv_restart;
    logic eng_drive, eng_busy, eng_done, eng_rx;
    logic [7:0] next_byte;

    owt_us_timer #(
        .CLK_PER_US(CLK_PER_US)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(eng_restart | conv_restart),
        .tick   (tick)
    );

    owt_slot_engine #(
        .RST_LOW_US (RST_LOW_US),
        .RST_HIGH_US(RST_HIGH_US),
        .PRES_US    (PRES_US),
        .SLOT_US    (SLOT_US),
        .REC_US     (REC_US),
        .LOW_US     (LOW_US),
        .SAMPLE_US  (SAMPLE_US)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmd_valid(st_q.cmd_valid),
        .cmd_kind (st_q.cmd_kind),
        .line_in  (bus_sense),
        .restart  (eng_restart),
        .drive_low(eng_drive),
        .busy     (eng_busy),
        .slot_done(eng_done),
        .rx_bit   (eng_rx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.cmd_valid = 1'b0;
        st_d.done      = 1'b0;
        st_d.err       = 1'b0;
        conv_restart   = 1'b0;
        next_byte      = '0;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.parasite  = parasite_mode;
                    st_d.pass      = 1'b0;
                    st_d.phase     = PH_RESET;
                    st_d.cmd_valid = 1'b1;
                    st_d.cmd_kind  = SK_RESET;
                end
            end
            PH_RESET: begin
                if (eng_done) begin
                    if (eng_rx) begin
                        // line stayed high: nobody answered
                        st_d.err   = 1'b1;
                        st_d.phase = PH_IDLE;
                    end else begin
                        st_d.phase     = PH_WRITE;
                        st_d.byte_idx  = 1'b0;
                        st_d.bit_idx   = '0;
                        next_byte      = cmd_byte(st_q.pass, 1'b0);
                        st_d.cmd_valid = 1'b1;
                        st_d.cmd_kind  = next_byte[0] ? SK_WR1 : SK_WR0;
                    end
                end
            end
            PH_WRITE: begin
                if (eng_done) begin
                    if (st_q.bit_idx == 3'd7 && st_q.byte_idx) begin
                        if (!st_q.pass) begin
                            st_d.phase    = PH_CONV;
                            st_d.conv_cnt = '0;
                            st_d.pu       = st_q.parasite;
                            conv_restart  = 1'b1;
                        end else begin
                            st_d.phase     = PH_READ;
                            st_d.rd_cnt    = '0;
                            st_d.cmd_valid = 1'b1;
                            st_d.cmd_kind  = SK_READ;
                        end
                    end else begin
                        if (st_q.bit_idx == 3'd7) begin
                            st_d.byte_idx = 1'b1;
                            st_d.bit_idx  = '0;
                        end else begin
                            st_d.bit_idx = st_q.bit_idx + 1'b1;
                        end
                        next_byte      = cmd_byte(st_q.pass, st_d.byte_idx);
                        st_d.cmd_valid = 1'b1;
                        st_d.cmd_kind  = next_byte[st_d.bit_idx] ? SK_WR1 : SK_WR0;
                    end
                end
            end
            PH_CONV: begin
                if (tick) begin
                    st_d.conv_cnt = st_q.conv_cnt + 1'b1;
                    if (st_d.conv_cnt == CV_END) begin
                        st_d.pu        = 1'b0;
                        st_d.pass      = 1'b1;
                        st_d.phase     = PH_RESET;
                        st_d.cmd_valid = 1'b1;
                        st_d.cmd_kind  = SK_RESET;
                    end
                end
            end
            PH_READ: begin
                if (eng_done) begin
                    st_d.shreg = {eng_rx, st_q.shreg[RD_BITS-1:1]};
                    if (st_q.rd_cnt == RD_LAST) begin
                        st_d.result = st_d.shreg;
                        st_d.done   = 1'b1;
                        st_d.phase  = PH_IDLE;
                    end else begin
                        st_d.rd_cnt    = st_q.rd_cnt + 1'b1;
                        st_d.cmd_valid = 1'b1;
                        st_d.cmd_kind  = SK_READ;
                    end
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEQ_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_drive_low = eng_drive;
    assign bus_strong_pu = st_q.pu;
    assign temp_raw      = st_q.result;
    assign done          = st_q.done;
    assign error         = st_q.err;

    logic par_latched;
    assign par_latched = st_q.parasite;

    AST_PU_NO_LOW: assert property (@(posedge clk) disable iff (!rst_n) !(bus_drive_low && bus_strong_pu)); // R7
    AST_PU_ONLY_PARASITE: assert property (@(posedge clk) disable iff (!rst_n) bus_strong_pu |-> par_latched); // R6
    AST_PU_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) bus_strong_pu |-> !eng_busy); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(temp_raw) |-> done); // R8
    AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n) !(done && error)); // R10

endmodule

// File: tb/owt_temp_reader_tb.sv
module owt_temp_reader_tb;
    localparam int C = 2;     // clocks per microsecond in this bench
    localparam int P = 200;   // conversion wait in microseconds

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic parasite_mode = 1'b0;
    logic slave_low = 1'b0;
    logic bus_sense;
    logic bus_drive_low, bus_strong_pu, done, error;
    logic [15:0] temp_raw;

    assign bus_sense = !(bus_drive_low | slave_low);

    owt_temp_reader #(
        .CLK_PER_US(C),
        .PULLUP_US (P)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .parasite_mode(parasite_mode),
        .bus_sense    (bus_sense),
        .bus_drive_low(bus_drive_low),
        .bus_strong_pu(bus_strong_pu),
        .temp_raw     (temp_raw),
        .done         (done),
        .error        (error)
    );

    // device model configuration (written only by the stimulus process)
    int          txn_id = 0;
    logic        ans_first = 1'b1, ans_second = 1'b1;
    logic [15:0] dev_word = 16'h0000;

    // device model observations (written only by the model)
    int seen_id = 0, t = 0, start_t = -1000000, last_start = -1;
    int nbytes = 0, nbits = 0, resets = 0, bad_len = 0, bad_rst = 0;
    int min_gap = 1 << 30, pu_clks = 0, overlap = 0, done_cnt = 0, err_cnt = 0;
    int bytes_at_pu = -1, pres_from = 0, pres_to = 0, tx_until = 0, tx_idx = 0, len = 0;
    logic dl_prev = 1'b0, pu_prev = 1'b0, tx_on = 1'b0, slot_tx = 1'b0;
    logic [7:0] shv = '0;
    logic [7:0] log_b [8];

    always @(negedge clk) begin
        t = t + 1;
        if (txn_id != seen_id) begin
            seen_id = txn_id; nbytes = 0; nbits = 0; resets = 0; bad_len = 0;
            bad_rst = 0; min_gap = 1 << 30; last_start = -1; pu_clks = 0;
            overlap = 0; done_cnt = 0; err_cnt = 0; bytes_at_pu = -1; tx_on = 1'b0;
        end
        if (bus_drive_low && !dl_prev) begin
            if (last_start >= 0 && (t - last_start) < min_gap) min_gap = t - last_start;
            last_start = t;
            start_t = t;
            slot_tx = tx_on;
            if (tx_on) begin
                if (!dev_word[tx_idx]) tx_until = t + 14 * C;
                tx_idx = tx_idx + 1;
                if (tx_idx == 16) tx_on = 1'b0;
            end
        end
        if (!bus_drive_low && dl_prev) begin
            len = t - start_t;
            if (len >= 400 * C) begin
                resets = resets + 1;
                if (len != 480 * C) bad_rst = bad_rst + 1;
                nbits = 0;
                tx_on = 1'b0;
                if ((resets == 1 && ans_first) || (resets == 2 && ans_second)) begin
                    pres_from = t + 15 * C;
                    pres_to   = t + 135 * C;
                end
            end else if (len != 60 * C && len != 2 * C) begin
                bad_len = bad_len + 1;
            end
        end
        if (t == start_t + 30 * C && !slot_tx) begin
            shv = {!bus_drive_low, shv[7:1]};
            nbits = nbits + 1;
            if (nbits == 8) begin
                if (nbytes < 8) log_b[nbytes] = shv;
                nbytes = nbytes + 1;
                nbits = 0;
                if (shv == 8'hBE) begin
                    tx_on = 1'b1;
                    tx_idx = 0;
                end
            end
        end
        slave_low = (t >= pres_from && t < pres_to) || (t < tx_until);
        if (bus_strong_pu) pu_clks = pu_clks + 1;
        if (bus_strong_pu && !pu_prev) bytes_at_pu = nbytes;
        if (bus_strong_pu && bus_drive_low) overlap = overlap + 1;
        if (done) done_cnt = done_cnt + 1;
        if (error) err_cnt = err_cnt + 1;
        dl_prev = bus_drive_low;
        pu_prev = bus_strong_pu;
    end

    int total = 0, bad = 0;
    logic wd_hit = 1'b0;
    logic [15:0] prev_word = 16'h0000;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_txn(input bit par, input logic [15:0] word, input bit a1,
                           input bit a2, input bit poke);
        ans_first = a1;
        ans_second = a2;
        dev_word = word;
        parasite_mode = par;
        txn_id = txn_id + 1;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        parasite_mode = !par;  // latched value must be used, not the live pin
        for (int k = 0; k < 16000; k++) begin
            @(negedge clk);
            start = (poke && k == 3000);
            if (done_cnt + err_cnt > 0) break;
        end
        start = 1'b0;
        repeat (300) @(negedge clk);
        if (a1 && a2) begin
            chk(done_cnt == 1, "R8 done pulses once", done_cnt, 1);
            chk(err_cnt == 0, "R8 no error", err_cnt, 0);
            chk(temp_raw == word, "R4 R8 temp_raw value", temp_raw, word);
            chk(nbytes == 4, "R2 byte count", nbytes, 4);
            chk({log_b[0], log_b[1], log_b[2], log_b[3]} == 32'hCC44CCBE, "R2 byte order",
                {log_b[0], log_b[1], log_b[2], log_b[3]}, 32'hCC44CCBE);
            chk(resets == 2 && bad_rst == 0, "R1 reset pulses", {resets, bad_rst}, 2 << 32);
            chk(bad_len == 0, "R3 slot low widths", bad_len, 0);
            chk(min_gap >= 62 * C, "R3 slot spacing", min_gap, 62 * C);
            if (par) begin
                chk(pu_clks == P * C, "R5 pull-up duration", pu_clks, P * C);
                chk(bytes_at_pu == 2, "R5 pull-up after convert byte", bytes_at_pu, 2);
            end else begin
                chk(pu_clks == 0, "R6 no pull-up", pu_clks, 0);
            end
            chk(overlap == 0, "R7 exclusive drives", overlap, 0);
            if (poke) chk(done_cnt == 1 && nbytes == 4 && resets == 2,
                          "R9 start during run ignored", nbytes, 4);
            prev_word = word;
        end else if (!a1) begin
            chk(err_cnt == 1 && done_cnt == 0, "R1 no presence error", err_cnt, 1);
            chk(resets == 1 && nbytes == 0, "R1 no slots after error", nbytes, 0);
            chk(temp_raw == prev_word, "R1 result kept", temp_raw, prev_word);
            chk(bad_rst == 0, "R1 reset width", bad_rst, 0);
        end else begin
            chk(err_cnt == 1 && done_cnt == 0, "R10 second presence error", err_cnt, 1);
            chk(resets == 2 && nbytes == 2, "R10 first half sent", nbytes, 2);
            chk(temp_raw == prev_word, "R10 result kept", temp_raw, prev_word);
            chk(pu_clks == (par ? P * C : 0), "R10 conversion wait", pu_clks, par ? P * C : 0);
        end
    endtask

    task automatic run_all();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!bus_drive_low && !bus_strong_pu && !done && !error, "R7 idle outputs",
            {bus_drive_low, bus_strong_pu, done, error}, 0);
        chk(temp_raw == 16'h0000, "R7 reset result", temp_raw, 0);
        run_txn(1'b1, 16'h0550, 1'b1, 1'b1, 1'b0);
        run_txn(1'b0, 16'hFC90, 1'b1, 1'b1, 1'b0);
        run_txn(1'b1, 16'h0000, 1'b1, 1'b1, 1'b0);
        run_txn(1'b0, 16'hFFFF, 1'b1, 1'b1, 1'b1);
        run_txn(1'b1, 16'hA5C3, 1'b0, 1'b1, 1'b0);
        run_txn(1'b1, 16'h8001, 1'b1, 1'b1, 1'b0);
        run_txn(1'b1, 16'h1234, 1'b1, 1'b0, 1'b0);
        run_txn(1'b0, 16'h7E18, 1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        if (wd_hit) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=expired expected=finished");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule